// File: doc/BRIEF.md
# Packed-Word Receive Path with Idle Timeout

This block sits behind a UART deserializer. It takes received characters one at a time and packs them four to a 32-bit word, with the earliest character in the lowest byte. Each completed word goes into a word-wide receive FIFO, which software drains through a read port. Software starts a receive transfer by writing the number of characters it expects. The transfer ends in one of two ways: the expected count arrives, or the line stays idle long enough to trigger a stale event. A command can also force the stale event.

When a transfer ends, the block latches how many characters arrived since the previous end into a snapshot count. A word that is only partly filled is pushed into the FIFO with its unused upper bytes set to zero. Software uses the snapshot to work out how many bytes of the final word are real. A stale event is one-shot: it sets a pending flag and disarms the idle timer. Separate commands clear the flag and re-arm the timer.

If a character arrives while the FIFO is full, it is dropped and not counted, and a sticky overrun flag is set. The same happens to a partial word that has to be flushed into a full FIFO. A watermark output is high while the number of stored words exceeds a programmed threshold.

Top module: `rxpk_rx_top`

## Requirements
- R1: Accepted characters fill a word in order: the first character goes to bits [7:0], the second to [15:8], the third to [23:16] and the fourth to [31:24]. The word enters the FIFO on the clock edge that accepts the fourth character.
- R2: Suppose the timer is armed and at least one character has arrived since the last transfer end. If a character is accepted in clock cycle C, the stale event fires in cycle C+`stale_tmo`+1, provided no further character arrives. `stale_pend` is then high after that cycle's edge. While the timer is disarmed, an idle line raises no stale event.
- R3: At a stale event, `snap_cnt` takes the number of characters accepted since the previous transfer end, and the character count restarts at zero. A partial word is pushed with its unused upper bytes set to zero. If no partial word is held, nothing is pushed.
- R4: Writing a transfer length starts a transfer and clears `xfer_done`. When the accepted count reaches the length, the transfer ends in the same way as a stale event (snapshot and flush), `xfer_done` is set and `stale_pend` stays low. A length larger than the FIFO is accepted, and the stale event then ends the transfer.
- R5: `cmd_stale_clr` lowers `stale_pend`. `cmd_stale_arm` arms the timer. Each stale event disarms the timer.
- R6: `cmd_stale_force` raises a stale event on the next edge, whatever the arm state and the idle time.
- R7: `rx_status` bit 0 is high while the FIFO holds a word, bit 1 while it is full, and bit 4 while overrun is set. Bits 2 and 3 read zero.
- R8: `wmark_irq` is high exactly while the stored word count is greater than `wmark`.
- R9: A character that arrives while the FIFO is full is dropped, is not counted and sets overrun. Overrun stays set until `cmd_err_clr`.
- R10: After reset the FIFO is empty, and the status, `stale_pend`, `snap_cnt`, `xfer_done` and `wmark_irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | A received character is present this cycle |
| rx_data | input | 8 | Received character |
| len_wr | input | 1 | Strobe that starts a transfer with `len_val` |
| len_val | input | CW | Expected transfer length in characters |
| stale_tmo | input | TMO_W | Idle cycles before a stale event |
| cmd_stale_clr | input | 1 | Clear the pending stale event |
| cmd_stale_arm | input | 1 | Arm the idle timer |
| cmd_stale_force | input | 1 | Raise a stale event now |
| cmd_err_clr | input | 1 | Clear the overrun flag |
| wmark | input | AW+1 | FIFO watermark threshold in words |
| rd_pop | input | 1 | Remove the head word from the FIFO |
| rd_word | output | 32 | Head word of the FIFO |
| snap_cnt | output | CW | Characters received in the last ended transfer |
| xfer_done | output | 1 | The programmed length was reached |
| rx_status | output | 5 | Status: bit0 ready, bit1 full, bit4 overrun |
| stale_pend | output | 1 | A stale event is pending |
| wmark_irq | output | 1 | Word count is above the watermark |

## Verification
A character lane that has slipped shows up as shuffled bytes in the very next FIFO word. A character count that is wrong shows up in `snap_cnt` after the next transfer end, or as a wrong padded tail word. An idle counter that is off by one moves the rise of `stale_pend` by a cycle, so the bench samples it one cycle before and one cycle after the expected edge. Overrun is checked by draining the FIFO after characters were dropped. The drained words must end exactly where the data written before the overflow ended.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;
  localparam int LANES = 4;

  // place a character into lane `lane` of a packing word
  function automatic logic [31:0] lane_insert(input logic [31:0] acc,
                                              input logic [1:0]  lane,
                                              input logic [7:0]  ch);
    logic [31:0] r;
    r = acc;
    r[int'(lane)*8 +: 8] = ch;
    return r;
  endfunction

  // keep the lowest `fill` lanes, zero the rest
  function automatic logic [31:0] pad_word(input logic [31:0] acc,
                                           input logic [1:0]  fill);
    logic [31:0] r;
    r = acc;
    for (int i = 0; i < LANES; i++) begin
      if (i >= int'(fill)) r[i*8 +: 8] = 8'h00;
    end
    return r;
  endfunction
endpackage

// File: rtl/rxpk_fifo.sv
module rxpk_fifo #(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [31:0]   wdata,
  input  logic          pop,
  output logic [31:0]   rdata,
  output logic [AW:0]   cnt,
  output logic          full,
  output logic          empty
);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_pop;

  assign full   = (cnt == FULL_CNT);
  assign empty  = (cnt == '0);
  assign do_pop = pop && !empty;
  assign rdata  = mem[rp];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (do_pop)        rp <= rp + 1'b1;
      if ((push && !full) && !do_pop)      cnt <= cnt + 1'b1;
      else if (!(push && !full) && do_pop) cnt <= cnt - 1'b1;
    end
  end

  // R9
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R7
  fifo_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (cnt == $past(cnt) + 1'b1));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/rxpk_stale_timer.sv
module rxpk_stale_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_vld,
  input  logic [TMO_W-1:0] tmo,
  input  logic             have_chars,
  input  logic             cmd_clr,
  input  logic             cmd_arm,
  input  logic             cmd_force,
  output logic             fire,
  output logic             pend,
  output logic             armed
);
  logic [TMO_W-1:0] idle;
  logic             idle_hit;

  assign idle_hit = (idle >= tmo);
  assign fire     = cmd_force || (armed && have_chars && !rx_vld && idle_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle  <= '0;
      pend  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (rx_vld)          idle <= '0;
      else if (idle != '1) idle <= idle + 1'b1;

      if (fire)         pend <= 1'b1;
      else if (cmd_clr) pend <= 1'b0;

      if (cmd_arm)   armed <= 1'b1;
      else if (fire) armed <= 1'b0;
    end
  end

  // R2
  stale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && !cmd_force) |-> !fire);

  // R5
  stale_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr && !fire) |=> !pend);

  // R5
  stale_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pend);
endmodule

// File: rtl/rxpk_packer.sv
module rxpk_packer
  import rxpk_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_vld,
  input  logic [7:0]    rx_data,
  input  logic          fifo_full,
  input  logic          len_wr,
  input  logic [CW-1:0] len_val,
  input  logic          stale_fire,
  input  logic          err_clr,
  output logic          push,
  output logic [31:0]   push_word,
  output logic          have_chars,
  output logic [CW-1:0] snap_cnt,
  output logic          xfer_done,
  output logic          ovr
);
  logic [31:0]   acc, acc_nx;
  logic [1:0]    lane, lane_nx;
  logic [CW-1:0] chars, chars_nx, len_q;
  logic          active;
  logic          accept, drop, len_hit, end_evt, word_full, flush_part, flush_lost;

  assign accept     = rx_vld && !fifo_full;
  assign drop       = rx_vld && fifo_full;
  assign acc_nx     = accept ? lane_insert(acc, lane, rx_data) : acc;
  assign lane_nx    = lane + 2'(accept);
  assign chars_nx   = (accept && chars != '1) ? chars + 1'b1 : chars;
  assign len_hit    = active && accept && (chars_nx == len_q);
  assign end_evt    = stale_fire || len_hit;
  assign word_full  = accept && (lane == 2'd3);
  assign flush_part = end_evt && (lane_nx != 2'd0);
  assign flush_lost = flush_part && fifo_full;
  assign push       = word_full || (flush_part && !fifo_full);
  assign push_word  = word_full ? acc_nx : pad_word(acc_nx, lane_nx);
  assign have_chars = (chars != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      lane      <= '0;
      chars     <= '0;
      len_q     <= '0;
      active    <= 1'b0;
      snap_cnt  <= '0;
      xfer_done <= 1'b0;
      ovr       <= 1'b0;
    end else begin
      if (end_evt) begin
        snap_cnt <= chars_nx;
        chars    <= '0;
        lane     <= '0;
        acc      <= '0;
        active   <= 1'b0;
        if (len_hit) xfer_done <= 1'b1;
      end else begin
        acc   <= word_full ? '0 : acc_nx;
        lane  <= lane_nx;
        chars <= chars_nx;
      end

      if (len_wr) begin
        len_q     <= len_val;
        active    <= 1'b1;
        xfer_done <= 1'b0;
        chars     <= '0;
        lane      <= '0;
        acc       <= '0;
      end

      if (drop || flush_lost) ovr <= 1'b1;
      else if (err_clr)       ovr <= 1'b0;
    end
  end

  // R9
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && fifo_full) |=> ovr);

  // R9
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !err_clr) |=> ovr);

  // R3
  end_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stale_fire && !len_wr) |=> (chars == '0 && lane == 2'd0));

  // R1
  lane_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !end_evt && !len_wr) |=> (lane == $past(lane) + 2'd1));
endmodule

// File: rtl/rxpk_rx_top.sv
module rxpk_rx_top #(
  parameter int DEPTH = 8,
  parameter int CW    = 16,
  parameter int TMO_W = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_vld,
  input  logic [7:0]       rx_data,
  input  logic             len_wr,
  input  logic [CW-1:0]    len_val,
  input  logic [TMO_W-1:0] stale_tmo,
  input  logic             cmd_stale_clr,
  input  logic             cmd_stale_arm,
  input  logic             cmd_stale_force,
  input  logic             cmd_err_clr,
  input  logic [AW:0]      wmark,
  input  logic             rd_pop,
  output logic [31:0]      rd_word,
  output logic [CW-1:0]    snap_cnt,
  output logic             xfer_done,
  output logic [4:0]       rx_status,
  output logic             stale_pend,
  output logic             wmark_irq
);
  logic          push, full, empty, ovr, have_chars, fire, armed;
  logic [31:0]   push_word;
  logic [AW:0]   cnt;

  rxpk_stale_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .tmo(stale_tmo),
    .have_chars(have_chars), .cmd_clr(cmd_stale_clr), .cmd_arm(cmd_stale_arm),
    .cmd_force(cmd_stale_force), .fire(fire), .pend(stale_pend), .armed(armed)
  );

  rxpk_packer #(.CW(CW)) u_pack (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_data(rx_data),
    .fifo_full(full), .len_wr(len_wr), .len_val(len_val), .stale_fire(fire),
    .err_clr(cmd_err_clr), .push(push), .push_word(push_word),
    .have_chars(have_chars), .snap_cnt(snap_cnt), .xfer_done(xfer_done), .ovr(ovr)
  );

  rxpk_fifo #(.DEPTH(DEPTH), .AW(AW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_word), .pop(rd_pop),
    .rdata(rd_word), .cnt(cnt), .full(full), .empty(empty)
  );

  assign rx_status = {ovr, 2'b00, full, !empty};
  assign wmark_irq = (cnt > wmark);

  // R7
  full_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_status[1] |-> rx_status[0]);

  // R5
  disarm_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cmd_stale_arm) |=> !armed);
endmodule

// File: tb/rxpk_rx_top_tb_top.sv
module rxpk_rx_top_tb_top;
  localparam int DEPTH = 8;
  localparam int CW    = 16;
  localparam int TMO_W = 8;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_vld = 0, len_wr = 0, cmd_stale_clr = 0, cmd_stale_arm = 0;
  logic cmd_stale_force = 0, cmd_err_clr = 0, rd_pop = 0;
  logic [7:0] rx_data = '0;
  logic [CW-1:0] len_val = '0;
  logic [TMO_W-1:0] stale_tmo = '0;
  logic [AW:0] wmark = '0;
  logic [31:0] rd_word;
  logic [CW-1:0] snap_cnt;
  logic xfer_done, stale_pend, wmark_irq;
  logic [4:0] rx_status;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  rxpk_rx_top #(.DEPTH(DEPTH), .CW(CW), .TMO_W(TMO_W)) dut_i (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    rx_vld = 1'b1; rx_data = b; @(negedge clk); rx_vld = 1'b0;
  endtask

  task automatic start_len(input int n);
    len_wr = 1'b1; len_val = CW'(n); @(negedge clk); len_wr = 1'b0;
  endtask

  task automatic do_clr();   cmd_stale_clr = 1;   @(negedge clk); cmd_stale_clr = 0;   endtask
  task automatic do_arm();   cmd_stale_arm = 1;   @(negedge clk); cmd_stale_arm = 0;   endtask
  task automatic do_force(); cmd_stale_force = 1; @(negedge clk); cmd_stale_force = 0; endtask

  task automatic pop_chk(input string req, input logic [31:0] exp);
    chk(req, "ready before pop", 32'(rx_status[0]), 32'd1);
    chk(req, "word", rd_word, exp);
    rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
  endtask

  task automatic wait_pend();
    for (int i = 0; i < 200 && !stale_pend; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10", "status", 32'(rx_status), 32'd0);
    chk("R10", "pend", 32'(stale_pend), 32'd0);
    chk("R10", "snap", 32'(snap_cnt), 32'd0);
    chk("R10", "done", 32'(xfer_done), 32'd0);
    chk("R10", "wmark irq", 32'(wmark_irq), 32'd0);
  endtask

  task automatic t_pack_and_timing();
    stale_tmo = 8'd6;
    start_len(100);          // R4: longer than the FIFO, stale ends it
    do_clr(); do_arm();
    send(8'h11); send(8'h22); send(8'h33); send(8'h44);
    chk("R1", "word order", rd_word, 32'h44332211);
    chk("R1", "ready", 32'(rx_status[0]), 32'd1);
    tick(6);
    chk("R2", "pend one cycle early", 32'(stale_pend), 32'd0);
    tick(1);
    chk("R2", "pend on time", 32'(stale_pend), 32'd1);
    chk("R3", "snapshot full word", 32'(snap_cnt), 32'd4);
    pop_chk("R1", 32'h44332211);
    chk("R3", "no empty flush", 32'(rx_status[0]), 32'd0);
  endtask

  task automatic t_partial();
    do_clr(); do_arm();
    send(8'hAA); send(8'hBB); send(8'hCC); send(8'hDD); send(8'hEE); send(8'hFF);
    wait_pend();
    chk("R3", "snapshot", 32'(snap_cnt), 32'd6);
    pop_chk("R3", 32'hDDCCBBAA);
    pop_chk("R3", 32'h0000FFEE);
    chk("R3", "drained", 32'(rx_status[0]), 32'd0);
  endtask

  task automatic t_disarmed_force();
    do_clr();
    chk("R5", "clear lowers pend", 32'(stale_pend), 32'd0);
    send(8'h01); send(8'h02);
    tick(40);
    chk("R5", "disarmed stays quiet", 32'(stale_pend), 32'd0);
    chk("R5", "no flush while idle", 32'(rx_status[0]), 32'd0);
    do_force();
    chk("R6", "forced pend", 32'(stale_pend), 32'd1);
    chk("R6", "forced snapshot", 32'(snap_cnt), 32'd2);
    pop_chk("R6", 32'h00000201);
  endtask

  task automatic t_length();
    do_clr();
    start_len(5);
    send(8'h10); send(8'h11); send(8'h12); send(8'h13); send(8'h14);
    chk("R4", "done", 32'(xfer_done), 32'd1);
    chk("R4", "snapshot", 32'(snap_cnt), 32'd5);
    chk("R4", "no stale", 32'(stale_pend), 32'd0);
    pop_chk("R4", 32'h13121110);
    pop_chk("R4", 32'h00000014);
  endtask

  task automatic t_wmark();
    wmark = 1;
    start_len(1000);
    chk("R4", "done cleared by new length", 32'(xfer_done), 32'd0);
    for (int i = 0; i < 4; i++) send(8'(i));
    chk("R8", "one word not above 1", 32'(wmark_irq), 32'd0);
    for (int i = 4; i < 8; i++) send(8'(i));
    chk("R8", "two words above 1", 32'(wmark_irq), 32'd1);
    pop_chk("R8", 32'h03020100);
    chk("R8", "back to one word", 32'(wmark_irq), 32'd0);
    pop_chk("R8", 32'h07060504);
  endtask

  task automatic t_overrun();
    start_len(1000);
    for (int i = 0; i < 32; i++) send(8'(i));
    chk("R7", "ready and full", 32'(rx_status), 32'h03);
    send(8'hF0); send(8'hF1); send(8'hF2); send(8'hF3);
    chk("R9", "overrun set", 32'(rx_status), 32'h13);
    pop_chk("R9", 32'h03020100);
    chk("R9", "overrun sticky", 32'(rx_status[4]), 32'd1);
    for (int w = 1; w < 8; w++)
      pop_chk("R9", {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
    chk("R9", "dropped bytes left nothing", 32'(rx_status[0]), 32'd0);
    do_force();
    chk("R9", "dropped bytes not counted", 32'(snap_cnt), 32'd32);
    chk("R9", "no flush of dropped data", 32'(rx_status[0]), 32'd0);
    cmd_err_clr = 1; @(negedge clk); cmd_err_clr = 0;
    chk("R9", "overrun cleared", 32'(rx_status), 32'h00);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_pack_and_timing();
    t_partial();
    t_disarmed_force();
    t_length();
    t_wmark();
    t_overrun();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule